// File: doc/BRIEF.md
# Load-Use Stall and Branch Squash Controller

This block decides, every cycle, whether a five-stage in-order integer pipeline advances, holds, or discards work. It keeps a compact copy of the control fields that travel through the decode register and the execute register. It compares the operand needs of the instruction in decode against a memory read sitting in execute. It also reacts to a branch or jump outcome that the execute stage computes.

A read-after-load conflict freezes the fetch address and the decode register for one cycle, and a harmless empty slot goes into execute in place of the dependent instruction. A taken control transfer in execute discards the two instructions fetched behind it and steers fetch to the target. When both events fall in the same cycle, the squash wins. The block does no operand forwarding and no prediction, and it holds no datapath. A short register model of the decode and execute stages lets the outputs be observed as a retirement stream.

Top module: `hazard_ctrl_unit`

## Requirements
- R1: A stall is raised when execute holds a valid memory read whose destination equals a source register that the valid decode instruction reads, on the first source or on the second.
- R2: While stalled, `pc_wr_en` and `dec_wr_en` are 0, `pc` keeps its value, and the held decode instruction is the next one that reaches execute.
- R3: While stalled, `ex_bubble` is 1, and in the following cycle `ex_valid`, `ex_store` and `ex_wb` are all 0.
- R4: A single load-use dependency costs exactly one stall cycle, and the dependent instruction reaches execute two cycles after the load.
- R5: When execute holds a valid control instruction and `ex_take` is 1, `squash` is 1 and `pc` equals `ex_target` in the next cycle. The two instructions fetched behind the branch never appear as valid in execute.
- R6: A control instruction with `ex_take` at 0 causes no squash and no stall. Fetch continues at `pc` + 4, and every instruction reaches execute in program order.
- R7: If a squash and a stall are both called for in one cycle, the squash takes priority: `pc_wr_en`, `dec_wr_en`, `ex_bubble` and `squash` are all 1, and `pc` loads the target.
- R8: A source register number of 0, or a source whose read-enable flag is 0, never causes a stall.
- R9: During reset `pc` is 0, `ex_valid` is 0, `squash` and `ex_bubble` are 0, and both write enables are 1.
- R10: A memory read followed by an instruction that uses neither of its registers causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fe_rs1 | input | 5 | First source register of the instruction at `pc` |
| fe_rs2 | input | 5 | Second source register of the instruction at `pc` |
| fe_use_rs1 | input | 1 | Instruction at `pc` reads its first source |
| fe_use_rs2 | input | 1 | Instruction at `pc` reads its second source |
| fe_rd | input | 5 | Destination register of the instruction at `pc` |
| fe_load | input | 1 | Instruction at `pc` reads memory |
| fe_store | input | 1 | Instruction at `pc` writes memory |
| fe_wb | input | 1 | Instruction at `pc` writes a register |
| fe_ctrl | input | 1 | Instruction at `pc` is a branch or jump |
| ex_take | input | 1 | Execute-stage outcome: the control transfer is taken |
| ex_target | input | 32 | Execute-stage target address |
| pc | output | 32 | Current fetch address |
| pc_wr_en | output | 1 | Fetch address advances or redirects this cycle |
| dec_wr_en | output | 1 | Decode register loads this cycle |
| ex_bubble | output | 1 | Execute register loads an empty slot this cycle |
| squash | output | 1 | Younger instructions are discarded this cycle |
| ex_valid | output | 1 | Execute holds a real instruction |
| ex_pc | output | 32 | Address of the instruction in execute |
| ex_store | output | 1 | Memory-write enable of the execute slot |
| ex_wb | output | 1 | Register-write enable of the execute slot |

## Verification
The assertions take for granted that the fetch-field inputs describe the instruction at the current `pc`, and that `ex_target` is stable and meaningful whenever a taken outcome is reported. They also take for granted that `ex_take` is only acted on while execute holds a control instruction, which the block enforces by gating. The bench feeds all fetch fields and the branch outcome from a small instruction table indexed by `pc` and `ex_pc`, so every input always belongs to the instruction that the pipeline model actually holds. Programs stay within the table's sixteen words, and each scenario starts from a fresh reset.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int unsigned RA_W = 5;
  localparam int unsigned PC_W = 32;

  // fields that continue into execute
  typedef struct packed {
    logic            valid;
    logic [RA_W-1:0] rd;
    logic            mem_rd;
    logic            mem_wr;
    logic            reg_wr;
    logic            is_ctrl;
    logic [PC_W-1:0] pc;
  } ex_slot_t;

  // decode-stage slot: execute fields plus operand needs
  typedef struct packed {
    ex_slot_t        core;
    logic [RA_W-1:0] rs1;
    logic [RA_W-1:0] rs2;
    logic            use1;
    logic            use2;
  } dec_slot_t;
endpackage

// File: rtl/hzc_loaduse.sv
module hzc_loaduse
  import hzc_pkg::*;
#(
  parameter int unsigned NSRC = 2
) (
  input  logic            dec_valid,
  input  logic [RA_W-1:0] dec_src [NSRC],
  input  logic            dec_use [NSRC],
  input  logic            ex_valid,
  input  logic            ex_mem_rd,
  input  logic [RA_W-1:0] ex_rd,
  output logic            stall
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = dec_use[g] && (dec_src[g] != '0) && (dec_src[g] == ex_rd);
  end

  assign stall = dec_valid && ex_valid && ex_mem_rd && (|hit);
endmodule

// File: rtl/hzc_arbiter.sv
module hzc_arbiter (
  input  logic stall,
  input  logic redirect,
  output logic pc_we,
  output logic dec_we,
  output logic ex_bubble,
  output logic squash
);
  // redirect outranks stall: the stalled instruction is on the wrong path
  always_comb begin
    squash    = redirect;
    pc_we     = 1'b1;
    dec_we    = 1'b1;
    ex_bubble = 1'b0;
    if (redirect) begin
      ex_bubble = 1'b1;
    end else if (stall) begin
      pc_we     = 1'b0;
      dec_we    = 1'b0;
      ex_bubble = 1'b1;
    end
  end
endmodule

// File: rtl/hzc_stage_regs.sv
module hzc_stage_regs
  import hzc_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter int unsigned     STEP     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dec_slot_t       fetch_d,
  input  logic            pc_we,
  input  logic            dec_we,
  input  logic            ex_bubble,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_q,
  output dec_slot_t       dec_q,
  output ex_slot_t        ex_q
);
  localparam logic [PC_W-1:0] INC = PC_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      dec_q <= '0;
      ex_q  <= '0;
    end else begin
      if (pc_we) pc_q <= redirect ? target : pc_q + INC;
      if (dec_we) dec_q <= redirect ? '0 : fetch_d;
      ex_q <= ex_bubble ? '0 : dec_q.core;
    end
  end
endmodule

// File: rtl/hazard_ctrl_unit.sv
module hazard_ctrl_unit
  import hzc_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter int unsigned     STEP     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] fe_rs1,
  input  logic [RA_W-1:0] fe_rs2,
  input  logic            fe_use_rs1,
  input  logic            fe_use_rs2,
  input  logic [RA_W-1:0] fe_rd,
  input  logic            fe_load,
  input  logic            fe_store,
  input  logic            fe_wb,
  input  logic            fe_ctrl,
  input  logic            ex_take,
  input  logic [PC_W-1:0] ex_target,
  output logic [PC_W-1:0] pc,
  output logic            pc_wr_en,
  output logic            dec_wr_en,
  output logic            ex_bubble,
  output logic            squash,
  output logic            ex_valid,
  output logic [PC_W-1:0] ex_pc,
  output logic            ex_store,
  output logic            ex_wb
);
  localparam int unsigned NSRC = 2;

  dec_slot_t       fetch_d, dec_q;
  ex_slot_t        ex_q;
  logic [RA_W-1:0] src [NSRC];
  logic            use_f [NSRC];
  logic            stall, redirect;

  always_comb begin
    fetch_d.core.valid   = 1'b1;
    fetch_d.core.rd      = fe_rd;
    fetch_d.core.mem_rd  = fe_load;
    fetch_d.core.mem_wr  = fe_store;
    fetch_d.core.reg_wr  = fe_wb;
    fetch_d.core.is_ctrl = fe_ctrl;
    fetch_d.core.pc      = pc;
    fetch_d.rs1          = fe_rs1;
    fetch_d.rs2          = fe_rs2;
    fetch_d.use1         = fe_use_rs1;
    fetch_d.use2         = fe_use_rs2;
  end

  assign src[0]   = dec_q.rs1;
  assign src[1]   = dec_q.rs2;
  assign use_f[0] = dec_q.use1;
  assign use_f[1] = dec_q.use2;
  assign redirect = ex_q.valid && ex_q.is_ctrl && ex_take;

  hzc_loaduse #(.NSRC(NSRC)) lu_i (
    .dec_valid (dec_q.core.valid),
    .dec_src   (src),
    .dec_use   (use_f),
    .ex_valid  (ex_q.valid),
    .ex_mem_rd (ex_q.mem_rd),
    .ex_rd     (ex_q.rd),
    .stall     (stall)
  );

  hzc_arbiter arb_i (
    .stall     (stall),
    .redirect  (redirect),
    .pc_we     (pc_wr_en),
    .dec_we    (dec_wr_en),
    .ex_bubble (ex_bubble),
    .squash    (squash)
  );

  hzc_stage_regs #(.RESET_PC(RESET_PC), .STEP(STEP)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_d   (fetch_d),
    .pc_we     (pc_wr_en),
    .dec_we    (dec_wr_en),
    .ex_bubble (ex_bubble),
    .redirect  (redirect),
    .target    (ex_target),
    .pc_q      (pc),
    .dec_q     (dec_q),
    .ex_q      (ex_q)
  );

  assign ex_valid = ex_q.valid;
  assign ex_pc    = ex_q.pc;
  assign ex_store = ex_q.mem_wr;
  assign ex_wb    = ex_q.reg_wr;
endmodule

// File: rtl/hzc_checker.sv
module hzc_checker
  import hzc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] ex_target,
  input logic [PC_W-1:0] pc,
  input logic            pc_wr_en,
  input logic            ex_bubble,
  input logic            squash,
  input logic            ex_valid,
  input logic            ex_store,
  input logic            ex_wb
);
  a_r2_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_wr_en |=> $stable(pc));

  a_r3_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |=> (!ex_valid && !ex_store && !ex_wb));

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_bubble && !squash) |=> !(ex_bubble && !squash));

  a_r5_target: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (pc == $past(ex_target)));

  a_r5_two_killed: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> ##1 !ex_valid);
endmodule

bind hazard_ctrl_unit hzc_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ex_target (ex_target),
  .pc        (pc),
  .pc_wr_en  (pc_wr_en),
  .ex_bubble (ex_bubble),
  .squash    (squash),
  .ex_valid  (ex_valid),
  .ex_store  (ex_store),
  .ex_wb     (ex_wb)
);

// File: tb/hazard_ctrl_unit_tb_top.sv
module hazard_ctrl_unit_tb_top;
  localparam time CLK_P = 10;
  localparam int  NCYC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [4:0]  fe_rs1, fe_rs2, fe_rd;
  logic        fe_use_rs1, fe_use_rs2, fe_load, fe_store, fe_wb, fe_ctrl;
  logic        ex_take;
  logic [31:0] ex_target, pc, ex_pc;
  logic        pc_wr_en, dec_wr_en, ex_bubble, squash, ex_valid, ex_store, ex_wb;

  // instruction table, word-indexed
  logic [4:0]  p_rs1 [16], p_rs2 [16], p_rd [16];
  logic        p_u1 [16], p_u2 [16], p_ld [16], p_st [16], p_wb [16], p_ct [16], p_tk [16];
  logic [31:0] p_tg [16];

  assign fe_rs1     = p_rs1[pc[5:2]];
  assign fe_rs2     = p_rs2[pc[5:2]];
  assign fe_rd      = p_rd[pc[5:2]];
  assign fe_use_rs1 = p_u1[pc[5:2]];
  assign fe_use_rs2 = p_u2[pc[5:2]];
  assign fe_load    = p_ld[pc[5:2]];
  assign fe_store   = p_st[pc[5:2]];
  assign fe_wb      = p_wb[pc[5:2]];
  assign fe_ctrl    = p_ct[pc[5:2]];
  assign ex_take    = p_ct[ex_pc[5:2]] && p_tk[ex_pc[5:2]];
  assign ex_target  = p_tg[ex_pc[5:2]];

  hazard_ctrl_unit dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] t_pc [NCYC], t_xpc [NCYC];
  logic        t_xv [NCYC], t_pwe [NCYC], t_dwe [NCYC], t_bub [NCYC], t_sq [NCYC];
  logic        t_xst [NCYC], t_xwb [NCYC];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) begin
      p_rs1[i] = 5'd1; p_rs2[i] = 5'd2; p_rd[i] = 5'd3;
      p_u1[i] = 1'b1; p_u2[i] = 1'b1; p_ld[i] = 1'b0; p_st[i] = 1'b0;
      p_wb[i] = 1'b1; p_ct[i] = 1'b0; p_tk[i] = 1'b0; p_tg[i] = '0;
    end
  endtask

  task automatic set_load(input int i, input logic [4:0] rd);
    p_ld[i] = 1'b1; p_rd[i] = rd; p_rs1[i] = 5'd8; p_u2[i] = 1'b0;
  endtask

  task automatic set_ctrl(input int i, input logic tk, input logic [31:0] tg);
    p_ct[i] = 1'b1; p_tk[i] = tk; p_tg[i] = tg; p_wb[i] = 1'b0;
  endtask

  // reset, then record NCYC cycles of outputs mid-cycle
  task automatic run_prog();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      t_pc[k] = pc; t_xpc[k] = ex_pc; t_xv[k] = ex_valid;
      t_pwe[k] = pc_wr_en; t_dwe[k] = dec_wr_en; t_bub[k] = ex_bubble; t_sq[k] = squash;
      t_xst[k] = ex_store; t_xwb[k] = ex_wb;
    end
  endtask

  // expect the retired stream: address per cycle, or 'x' for an empty slot
  task automatic chk_ex(input string what, input int k, input logic v, input logic [31:0] a);
    chk({what, " ex_valid"}, 32'(t_xv[k]), 32'(v));
    if (v) chk({what, " ex_pc"}, t_xpc[k], a);
  endtask

  task automatic t_reset();
    clear_prog();
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R9 pc in reset", pc, 32'h0);
    chk("R9 ex_valid in reset", 32'(ex_valid), 32'h0);
    chk("R9 squash in reset", 32'(squash), 32'h0);
    chk("R9 bubble in reset", 32'(ex_bubble), 32'h0);
    chk("R9 enables in reset", {30'h0, pc_wr_en, dec_wr_en}, 32'h3);
  endtask

  task automatic t_load_dep_rs1();
    clear_prog();
    set_load(0, 5'd5);
    p_rs1[1] = 5'd5; p_rd[1] = 5'd9;
    run_prog();
    chk("R1 stall raised", 32'(t_bub[2]), 32'h1);
    chk("R2 pc enable low", 32'(t_pwe[2]), 32'h0);
    chk("R2 decode enable low", 32'(t_dwe[2]), 32'h0);
    chk("R2 pc held", t_pc[3], 32'h8);
    chk_ex("R3 bubble slot", 3, 1'b0, '0);
    chk("R3 bubble no writes", {30'h0, t_xst[3], t_xwb[3]}, 32'h0);
    chk("R4 no second stall", 32'(t_bub[3]), 32'h0);
    chk("R4 resumes pc", t_pc[4], 32'hC);
    chk_ex("R1 load in ex", 2, 1'b1, 32'h0);
    chk_ex("R2 held instr enters ex", 4, 1'b1, 32'h4);
    chk_ex("R4 next in order", 5, 1'b1, 32'h8);
  endtask

  task automatic t_load_dep_rs2();
    clear_prog();
    set_load(0, 5'd6);
    p_rs2[1] = 5'd6;
    run_prog();
    chk("R1 second source stalls", 32'(t_bub[2]), 32'h1);
    chk_ex("R4 dependent after one bubble", 4, 1'b1, 32'h4);
  endtask

  task automatic t_load_indep();
    clear_prog();
    set_load(0, 5'd5);
    p_rs1[1] = 5'd6; p_rs2[1] = 5'd7;
    run_prog();
    chk("R10 no stall", 32'(t_bub[2]), 32'h0);
    chk("R10 pc advances", t_pc[3], 32'hC);
    chk_ex("R10 consumer follows load", 3, 1'b1, 32'h4);
  endtask

  task automatic t_zero_and_unused();
    clear_prog();
    set_load(0, 5'd0);
    p_rs1[1] = 5'd0;
    set_load(2, 5'd7);
    p_rs2[3] = 5'd7; p_u2[3] = 1'b0;
    run_prog();
    chk("R8 register zero no stall", 32'(t_bub[2]), 32'h0);
    chk("R8 unused source no stall", 32'(t_bub[4]), 32'h0);
    chk_ex("R8 stream unbroken", 5, 1'b1, 32'hC);
  endtask

  task automatic t_taken();
    clear_prog();
    set_ctrl(0, 1'b1, 32'h20);
    p_st[8] = 1'b1;
    run_prog();
    chk("R5 squash raised", 32'(t_sq[2]), 32'h1);
    chk("R5 pc loads target", t_pc[3], 32'h20);
    chk("R5 pc after target", t_pc[4], 32'h24);
    chk_ex("R5 branch itself retires", 2, 1'b1, 32'h0);
    chk_ex("R5 first younger killed", 3, 1'b0, '0);
    chk_ex("R5 second younger killed", 4, 1'b0, '0);
    chk_ex("R5 target retires", 5, 1'b1, 32'h20);
    chk("R5 target store flag", 32'(t_xst[5]), 32'h1);
  endtask

  task automatic t_not_taken();
    clear_prog();
    set_ctrl(0, 1'b0, 32'h20);
    run_prog();
    chk("R6 no squash", 32'(t_sq[2]), 32'h0);
    chk("R6 no bubble", 32'(t_bub[2]), 32'h0);
    chk("R6 sequential pc", t_pc[3], 32'hC);
    chk_ex("R6 branch retires", 2, 1'b1, 32'h0);
    chk_ex("R6 fall-through retires", 3, 1'b1, 32'h4);
    chk_ex("R6 order kept", 4, 1'b1, 32'h8);
  endtask

  task automatic t_taken_over_wrong_path_load();
    clear_prog();
    set_ctrl(0, 1'b1, 32'h20);
    set_load(1, 5'd5);
    p_rs1[2] = 5'd5;
    run_prog();
    chk("R5 squash on branch", 32'(t_sq[2]), 32'h1);
    chk("R7 wrong-path load no stall", 32'(t_bub[3]), 32'h0);
    chk("R7 pc keeps moving", t_pc[4], 32'h24);
    chk_ex("R5 wrong-path load gone", 3, 1'b0, '0);
    chk_ex("R5 wrong-path consumer gone", 4, 1'b0, '0);
    chk_ex("R5 target retires", 5, 1'b1, 32'h20);
  endtask

  task automatic t_same_cycle_priority();
    clear_prog();
    set_load(0, 5'd5);
    set_ctrl(0, 1'b1, 32'h30);
    p_rs1[1] = 5'd5;
    run_prog();
    chk("R7 squash wins", 32'(t_sq[2]), 32'h1);
    chk("R7 enables high", {30'h0, t_pwe[2], t_dwe[2]}, 32'h3);
    chk("R7 bubble high", 32'(t_bub[2]), 32'h1);
    chk("R7 pc redirected", t_pc[3], 32'h30);
    chk_ex("R7 stalled instr discarded", 4, 1'b0, '0);
    chk_ex("R7 target retires", 5, 1'b1, 32'h30);
  endtask

  initial begin
    clear_prog();
    t_reset();
    t_load_dep_rs1();
    t_load_dep_rs2();
    t_load_indep();
    t_zero_and_unused();
    t_taken();
    t_not_taken();
    t_taken_over_wrong_path_load();
    t_same_cycle_priority();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule